// File: doc/BRIEF.md
# Random Number Generator Register Front-End

This block sits between a simple register bus and a true random number source. Software programs a control word, polls a status word and pops 32-bit random words from a small output queue. Entropy words arrive on a valid/data pair from the noise source. A health-test input reports seed failures, and a clock-check input reports clock faults.

Configuration of the conditioning stage is protected. The 18-bit configuration field, which contains the 4-bit noise clock divider in its upper part, is taken only from a control write that also sets the conditioning-reset bit. That bit starts a reset cycle. The cycle stays active while software holds the bit at 1. After software writes it back to 0, the cycle runs for a fixed number of clock cycles and then hardware clears the bit. A completed cycle empties the queue and clears the live seed-error flag. The sticky copy of that flag stays set until software clears it.

Top module: `trng_regfront`

## Requirements
- R1: After reset, the control word and the status word read as zero, the queue is empty and `irq` is low.
- R2: Byte offset 0x00 holds the control word and 0x04 holds the status word. Reading 0x08 returns data. In the control word, bit 2 enables generation, bit 3 enables the interrupt and bit 5 masks clock-error detection. These three bits can be written at any time and read back.
- R3: The queue holds FIFO_DEPTH words (default 4). A noise word is accepted only when all of these hold: generation is enabled, no reset cycle is active, no seed error is live and the queue is not full. Status bit 0 is 1 exactly when the queue is not empty.
- R4: When the seed-error input is asserted, the next status read shows live bit 2 and sticky bit 6 both set. The queue is emptied and no further words are accepted while the live bit stays set.
- R5: Control bits 25:8 (configuration, with the divider at 19:16) load only from a control write that has bit 30 at 1. A control write with bit 30 at 0 leaves them unchanged.
- R6: Bit 30 reads 1 from the write that sets it and while software keeps it at 1. After software writes it back to 0, it keeps reading 1 for RST_CYCLES further cycles (default 16). Hardware then clears it.
- R7: While the reset cycle is active, the queue stays empty and no noise word is accepted. When the cycle finishes, the live seed-error bit is cleared and the sticky bit is left unchanged.
- R8: A read at 0x08 returns the oldest queued word and removes it, so words come out in arrival order. A read when the queue is empty, including any read while a seed error is live, returns zero and changes nothing.
- R9: Writing 0 to status bit 5 or bit 6 clears that sticky bit. Writing 1 to either has no effect. Bits 0, 1 and 2 cannot be changed by writes.
- R10: Live clock-error bit 1 equals the clock-error input unless control bit 5 masks it. Sticky bit 5 is set on every cycle in which the live bit is 1.
- R11: `irq` is high when control bit 3 is set and at least one of these is true: the queue is not empty, the sticky seed-error bit is set, or the sticky clock-error bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe; a read of the data offset removes a word |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| noise_valid | input | 1 | Entropy word present this cycle |
| noise_word | input | 32 | Entropy word |
| seed_err_i | input | 1 | Seed failure reported by the health tests |
| clk_err_i | input | 1 | Clock fault reported by the clock check |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every bus strobe lasts exactly one cycle and that read and write are never asserted together. They also assume the noise source never offers a zero word, so a zero read always means "no data". The stimulus drives each access as a single-cycle pulse and generates noise words from a nonzero base. Seed and clock faults are raised only at points where the queue contents and the reset-cycle state are already known, so each fault's effect on the flags and the queue can be seen in isolation.

// File: rtl/trng_pkg.sv
package trng_pkg;

    // Register byte offsets (software depends on these)
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_DATA = 'h08;

    // Control word bit positions
    localparam int CB_EN      = 2;
    localparam int CB_IE      = 3;
    localparam int CB_CEDOFF  = 5;
    localparam int CB_CFG_LO  = 8;
    localparam int CB_CFG_HI  = 25;
    localparam int CB_CRST    = 30;

    // Status word bit positions
    localparam int SB_READY   = 0;
    localparam int SB_CLK_LV  = 1;
    localparam int SB_SEED_LV = 2;
    localparam int SB_CLK_ST  = 5;
    localparam int SB_SEED_ST = 6;

    localparam int CFG_W = CB_CFG_HI - CB_CFG_LO + 1;

    typedef enum logic [1:0] {
        CRST_IDLE = 2'd0,
        CRST_HOLD = 2'd1,
        CRST_RUN  = 2'd2
    } crst_state_e;

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             ced_off;
        logic [CFG_W-1:0] cfg;
    } ctrl_t;

    function automatic logic [31:0] pack_ctrl(ctrl_t c, logic busy);
        logic [31:0] v;
        v = '0;
        v[CB_EN]                = c.en;
        v[CB_IE]                = c.ie;
        v[CB_CEDOFF]            = c.ced_off;
        v[CB_CFG_HI:CB_CFG_LO]  = c.cfg;
        v[CB_CRST]              = busy;
        return v;
    endfunction

    function automatic logic [31:0] pack_stat(logic rdy, logic clk_lv, logic seed_lv,
                                              logic clk_st, logic seed_st);
        logic [31:0] v;
        v = '0;
        v[SB_READY]   = rdy;
        v[SB_CLK_LV]  = clk_lv;
        v[SB_SEED_LV] = seed_lv;
        v[SB_CLK_ST]  = clk_st;
        v[SB_SEED_ST] = seed_st;
        return v;
    endfunction

endpackage

// File: rtl/trng_word_fifo.sv
module trng_word_fifo #(
    parameter int DEPTH = 4,   // power of two
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) mem[wptr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wptr_q <= wptr_q + PTR_W'(1);
            if (pop)  rptr_q <= rptr_q + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout  = mem[rptr_q];
    assign count = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/trng_condrst.sv
module trng_condrst
    import trng_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,    // control write with reset bit = 1
    input  logic release_i,  // control write with reset bit = 0
    output logic busy_o,
    output logic done_o
);
    crst_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy_o = (state_q != CRST_IDLE);
    assign done_o = (state_q == CRST_RUN) && (cnt_q == '0) && !start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CRST_IDLE;
            cnt_q   <= '0;
        end else if (start_i) begin
            state_q <= CRST_HOLD;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                CRST_HOLD: if (release_i) begin
                    state_q <= CRST_RUN;
                    cnt_q   <= CNT_W'(RST_CYCLES - 1);
                end
                CRST_RUN: begin
                    if (cnt_q == '0) state_q <= CRST_IDLE;
                    else             cnt_q   <= cnt_q - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trng_regfront.sv
module trng_regfront
    import trng_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int RST_CYCLES = 16,
    localparam int FCNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              noise_valid,
    input  logic [31:0]       noise_word,
    input  logic              seed_err_i,
    input  logic              clk_err_i,
    output logic              irq
);
    ctrl_t ctrl_q;
    logic  secs_q, seis_q, ceis_q;
    logic  sel_ctrl, sel_stat, sel_data;
    logic  wr_ctrl, wr_stat, rd_data;
    logic  crst_busy, crst_done;
    logic  clk_live;
    logic  f_push, f_pop, f_flush, f_empty, f_full;
    logic [31:0]       f_dout;
    logic [FCNT_W-1:0] fifo_count;
    logic  unused_wbits;

    assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
    assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
    assign wr_ctrl  = bus_wr & sel_ctrl;
    assign wr_stat  = bus_wr & sel_stat;
    assign rd_data  = bus_rd & sel_data;

    assign unused_wbits = ^{bus_wdata[31], bus_wdata[29:26], bus_wdata[7],
                            bus_wdata[4], bus_wdata[1:0]};

    trng_condrst #(.RST_CYCLES(RST_CYCLES)) u_crst (
        .clk       (clk),
        .rst       (rst),
        .start_i   (wr_ctrl &  bus_wdata[CB_CRST]),
        .release_i (wr_ctrl & ~bus_wdata[CB_CRST]),
        .busy_o    (crst_busy),
        .done_o    (crst_done)
    );

    assign f_flush = seed_err_i | secs_q | crst_busy;
    assign f_push  = noise_valid & ctrl_q.en & ~crst_busy & ~secs_q
                   & ~seed_err_i & ~f_full;
    assign f_pop   = rd_data & ~f_empty;

    trng_word_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (f_flush),
        .push  (f_push),
        .din   (noise_word),
        .pop   (f_pop),
        .dout  (f_dout),
        .count (fifo_count),
        .empty (f_empty),
        .full  (f_full)
    );

    assign clk_live = clk_err_i & ~ctrl_q.ced_off;

    // Control: enable bits anytime, configuration only with reset bit set
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.en      <= bus_wdata[CB_EN];
            ctrl_q.ie      <= bus_wdata[CB_IE];
            ctrl_q.ced_off <= bus_wdata[CB_CEDOFF];
            if (bus_wdata[CB_CRST])
                ctrl_q.cfg <= bus_wdata[CB_CFG_HI:CB_CFG_LO];
        end
    end

    // Error flags: live seed error cleared by finished reset cycle,
    // sticky flags cleared by writing zero
    always_ff @(posedge clk) begin
        if (rst) begin
            secs_q <= 1'b0;
            seis_q <= 1'b0;
            ceis_q <= 1'b0;
        end else begin
            if (seed_err_i)     secs_q <= 1'b1;
            else if (crst_done) secs_q <= 1'b0;

            if (seed_err_i)                              seis_q <= 1'b1;
            else if (wr_stat && !bus_wdata[SB_SEED_ST])  seis_q <= 1'b0;

            if (clk_live)                                ceis_q <= 1'b1;
            else if (wr_stat && !bus_wdata[SB_CLK_ST])   ceis_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)
            bus_rdata = pack_ctrl(ctrl_q, crst_busy);
        else if (sel_stat)
            bus_rdata = pack_stat(~f_empty, clk_live, secs_q, ceis_q, seis_q);
        else if (sel_data)
            bus_rdata = f_empty ? '0 : f_dout;
    end

    assign irq = ctrl_q.ie & (~f_empty | seis_q | ceis_q);
endmodule

// File: rtl/trng_regfront_chk.sv
module trng_regfront_chk
    import trng_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int FCNT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              noise_valid,
    input logic              seed_err_i,
    input logic [FCNT_W-1:0] fifo_count,
    input logic              secs_q,
    input logic              seis_q,
    input logic              crst_busy,
    input logic              crst_done,
    input logic [CFG_W-1:0]  cfg
);
    AST_SEED_SETS_BOTH: assert property (@(posedge clk) disable iff (rst)
        seed_err_i |=> (secs_q && seis_q));                               // R4

    AST_SEED_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        secs_q |-> (fifo_count == '0));                                  // R4

    AST_READY_BIT: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_STAT) && fifo_count != '0)
        |-> bus_rdata[SB_READY]);                                        // R3

    AST_CFG_GUARDED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && !bus_wdata[CB_CRST])
        |=> $stable(cfg));                                               // R5

    AST_CRST_HELD: assert property (@(posedge clk) disable iff (rst)
        (crst_busy && !crst_done) |=> crst_busy);                        // R6

    AST_CRST_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(crst_busy) |-> (fifo_count == '0));                        // R7

    AST_FINISH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($fell(crst_busy) && !$past(seed_err_i)) |-> !secs_q);           // R7

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_DATA) && fifo_count == '0)
        |-> (bus_rdata == '0));                                          // R8

    AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_DATA) && fifo_count == '0 && !noise_valid)
        |=> (fifo_count == '0));                                         // R8
endmodule

bind trng_regfront trng_regfront_chk #(.ADDR_W(ADDR_W), .FCNT_W(FCNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .noise_valid (noise_valid),
    .seed_err_i  (seed_err_i),
    .fifo_count  (fifo_count),
    .secs_q      (secs_q),
    .seis_q      (seis_q),
    .crst_busy   (crst_busy),
    .crst_done   (crst_done),
    .cfg         (ctrl_q.cfg)
);

// File: tb/test_trng_regfront.sv
module test_trng_regfront;
    localparam int AW = 4;
    localparam int NRST = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_rd = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          noise_valid = 1'b0;
    logic [31:0]   noise_word = 32'hC0DE_0000;
    logic          seed_err_i = 1'b0, clk_err_i = 1'b0;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    trng_regfront #(.ADDR_W(AW), .FIFO_DEPTH(4), .RST_CYCLES(NRST)) i_trng_regfront (
        .clk, .rst, .bus_rd, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .noise_valid, .noise_word, .seed_err_i, .clk_err_i, .irq
    );

    // ---------------- behavioural reference model ----------------
    bit          m_en, m_ie, m_ced;
    bit [17:0]   m_cfg;
    int          m_phase;   // 0 idle, 1 held, 2 counting
    int          m_left;
    bit          m_secs, m_seis, m_ceis;
    logic [31:0] m_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_ie = 0; m_ced = 0; m_cfg = 0;
            m_phase = 0; m_left = 0;
            m_secs = 0; m_seis = 0; m_ceis = 0;
            m_q.delete();
        end else begin
            bit wc, ws, rdd, take, finish, clive;
            wc  = bus_wr && bus_addr == 4'h0;
            ws  = bus_wr && bus_addr == 4'h4;
            rdd = bus_rd && bus_addr == 4'h8;
            take = noise_valid && m_en && m_phase == 0 && !m_secs && !seed_err_i
                   && m_q.size() < 4;
            clive = clk_err_i && !m_ced;
            finish = 0;
            if (rdd && m_q.size() > 0) void'(m_q.pop_front());
            if (take) m_q.push_back(noise_word);
            if (seed_err_i || m_secs || m_phase != 0) m_q.delete();
            if (wc && bus_wdata[30]) begin
                m_phase = 1; m_left = 0;
            end else if (m_phase == 1 && wc) begin
                m_phase = 2; m_left = NRST - 1;
            end else if (m_phase == 2) begin
                if (m_left == 0) begin m_phase = 0; finish = 1; end
                else m_left--;
            end
            if (wc) begin
                m_en = bus_wdata[2]; m_ie = bus_wdata[3]; m_ced = bus_wdata[5];
                if (bus_wdata[30]) m_cfg = bus_wdata[25:8];
            end
            if (seed_err_i) m_secs = 1; else if (finish) m_secs = 0;
            if (seed_err_i) m_seis = 1; else if (ws && !bus_wdata[6]) m_seis = 0;
            if (clive) m_ceis = 1; else if (ws && !bus_wdata[5]) m_ceis = 0;
        end
    end

    function automatic logic [31:0] model_rdata();
        logic [31:0] v = '0;
        if (bus_addr == 4'h0) begin
            v[2] = m_en; v[3] = m_ie; v[5] = m_ced; v[25:8] = m_cfg;
            v[30] = (m_phase != 0);
        end else if (bus_addr == 4'h4) begin
            v[0] = (m_q.size() != 0); v[1] = clk_err_i && !m_ced;
            v[2] = m_secs; v[5] = m_ceis; v[6] = m_seis;
        end else if (bus_addr == 4'h8) begin
            v = (m_q.size() != 0) ? m_q[0] : 32'h0;
        end
        return v;
    endfunction

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [31:0] er;
            bit ei;
            er = model_rdata();
            ei = m_ie && (m_q.size() != 0 || m_seis || m_ceis);
            checks++;
            if (bus_rdata !== er) begin
                fails++;
                $display("FAIL R2/R8 model rdata addr=%h actual=%h expected=%h", bus_addr, bus_rdata, er);
            end
            checks++;
            if (irq !== ei) begin
                fails++;
                $display("FAIL R11 model irq actual=%b expected=%b", irq, ei);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [3:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    always @(posedge clk) if (noise_valid) #1 noise_word <= noise_word + 1;

    initial begin
        #(2_000_000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        noise_word = 32'hC0DE_0001;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        rd_reg(4'h0, d); check("R1 ctrl after reset", d, 32'h0);
        rd_reg(4'h4, d); check("R1 stat after reset", d, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // enable, fill past the queue depth
        wr_reg(4'h0, 32'h0000_0004);
        noise_valid = 1'b1;
        repeat (6) tick();
        noise_valid = 1'b0;
        rd_reg(4'h4, d); check("R3 ready with queued words", d, 32'h1);
        rd_reg(4'h8, d); check("R8 first word", d, 32'hC0DE_0001);
        rd_reg(4'h8, d); check("R8 second word", d, 32'hC0DE_0002);
        rd_reg(4'h8, d); check("R8 third word", d, 32'hC0DE_0003);
        rd_reg(4'h8, d); check("R3 depth limit, fourth word", d, 32'hC0DE_0004);
        rd_reg(4'h8, d); check("R8 empty read", d, 32'h0);
        rd_reg(4'h4, d); check("R8 empty read keeps queue empty", d, 32'h0);

        // configuration without the reset bit is ignored
        wr_reg(4'h0, 32'h000F_0D04);
        rd_reg(4'h0, d); check("R5 cfg ignored", d, 32'h0000_0004);

        // configuration with reset bit, then release and time the cycle
        wr_reg(4'h0, 32'h4180_1004);
        rd_reg(4'h0, d); check("R5 R6 cfg captured, bit held", d, 32'h4180_1004);
        wr_reg(4'h0, 32'h0180_1004);
        noise_valid = 1'b1;
        repeat (14) tick();
        rd_reg(4'h4, d); check("R7 nothing queued during reset cycle", d, 32'h0);
        rd_reg(4'h0, d); check("R6 bit still 1 at last cycle", d, 32'h4180_1004);
        rd_reg(4'h0, d); check("R6 bit cleared by hardware", d, 32'h0180_1004);
        noise_valid = 1'b0;
        rd_reg(4'h4, d); check("R3 accepting again after cycle", d, 32'h1);

        // seed error
        seed_err_i = 1'b1; tick(); seed_err_i = 1'b0;
        rd_reg(4'h4, d); check("R4 live and sticky seed bits", d, 32'h44);
        rd_reg(4'h8, d); check("R8 data read under seed error", d, 32'h0);
        noise_valid = 1'b1; repeat (3) tick(); noise_valid = 1'b0;
        rd_reg(4'h4, d); check("R4 generation stopped", d, 32'h44);

        wr_reg(4'h0, 32'h4180_1004);
        wr_reg(4'h0, 32'h0180_1004);
        repeat (NRST) tick();
        rd_reg(4'h4, d); check("R7 live cleared, sticky kept", d, 32'h40);
        wr_reg(4'h4, 32'hFFFF_FFFF);
        rd_reg(4'h4, d); check("R9 write one no effect", d, 32'h40);
        wr_reg(4'h4, 32'h0);
        rd_reg(4'h4, d); check("R9 write zero clears sticky", d, 32'h0);

        // clock error
        clk_err_i = 1'b1; tick();
        rd_reg(4'h4, d); check("R10 live and sticky clock bits", d, 32'h22);
        clk_err_i = 1'b0;
        rd_reg(4'h4, d); check("R10 sticky remains", d, 32'h20);
        wr_reg(4'h0, 32'h0180_1024);
        clk_err_i = 1'b1; tick();
        rd_reg(4'h4, d); check("R10 masked live bit", d, 32'h20);
        clk_err_i = 1'b0;
        rd_reg(4'h0, d); check("R2 mask bit readback", d, 32'h0180_1024);

        // interrupt
        wr_reg(4'h0, 32'h0180_102C);
        check("R11 irq from sticky clock bit", {31'b0, irq}, 32'h1);
        rd_reg(4'h0, d); check("R2 enable bits readback", d, 32'h0180_102C);
        wr_reg(4'h4, 32'h0);
        check("R11 irq low after clear", {31'b0, irq}, 32'h0);
        noise_valid = 1'b1; tick(); noise_valid = 1'b0;
        check("R11 irq from queued word", {31'b0, irq}, 32'h1);
        rd_reg(4'h8, d);
        check("R11 irq low after drain", {31'b0, irq}, 32'h0);

        repeat (2) tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule